// File: doc/BRIEF.md
# Channel Multiplexer Configuration Register

This block holds the per-channel setup of an eight-input simultaneous-sampling converter front end. A host loads it one channel at a time through a shared 8-bit bus. Each write is taken on the rising edge of a write strobe while chip select is low. The stored entries give the set of selected channels, the pairing of neighbouring channels into differential inputs, which member of each pair is positive, and the unipolar or bipolar coding of every channel. The entries also hold a power-down flag and an address that points the read port at one result location.

A write also decides whether a conversion starts. When it does, the block gives the sequencer a one-cycle start pulse and the mask of channels to convert. Input coding and pairing changes are staged. They take effect only at the conversion after the one started by the same write. A channel selection, or a polarity swap made through the low address bit, takes effect at once. A strap input bypasses the stored entries and picks one of four fixed arrangements.

Top module: `chmux_cfg_reg`

## Requirements
- R1: A write is taken only on a rising edge of `wr_strobe` seen while `cs_n` is low. A strobe held high counts once. A strobe with `cs_n` high changes no output and starts nothing.
- R2: After reset no channel is selected, every pair is single-ended with no swap, every channel is unipolar, power-down is off, the read address is 0 and no start or load pulse is present.
- R3: With `hw_en` low, a write whose bit4 (inhibit) and bit3 (power-down) are both 0 gives a one-cycle `conv_start` in the cycle after the strobe edge. Any other write starts nothing.
- R4: Every write with `hw_en` low marks the channel at bits 2..0 as selected. Selections build up over many writes and are cleared only by reset.
- R5: For a started conversion, `conv_mask` is the one-hot addressed channel when bit7 (single) is 1. When bit7 is 0 it is the whole selected set, including the channel this write addresses.
- R6: Bit5 (bipolar) of a write goes to a pending copy for the addressed channel. Bit6 (differential) goes to a pending copy for its pair (address bits 2..1). `chan_bip` and `pair_diff` take the pending copies only when a conversion starts, and they use the values held before that write.
- R7: A write with bit6 = 1 sets `pair_swap` of its pair to address bit0 at once: 0 makes the even channel positive, 1 the odd one. The last such write to a pair wins.
- R8: `power_down` follows bit3 of the most recent accepted write with `hw_en` low. Entries written while powered down are kept.
- R9: A write with `hw_en` low and bit4 = 1 loads `rd_addr` with bits 2..0 and gives a one-cycle `rd_load` in the cycle after the strobe edge.
- R10: With `hw_en` high the bus data is ignored and the stored entries are left untouched. Every accepted write starts a conversion of all eight channels. `hw_sel[0]` = 1 pairs all channels differentially with no swap, `hw_sel[1]` = 1 makes all channels bipolar, and `power_down` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_strobe | input | 1 | Write strobe, taken on its rising edge |
| wr_bus | input | 8 | Write data: [2:0] address, 3 power-down, 4 inhibit, 5 bipolar, 6 differential, 7 single |
| hw_en | input | 1 | Strap: 1 uses the fixed arrangements |
| hw_sel | input | 2 | Fixed arrangement: bit0 differential, bit1 bipolar |
| conv_start | output | 1 | One-cycle conversion start |
| conv_mask | output | 8 | Channels to convert, valid with `conv_start` |
| chan_sel | output | 8 | Stored selected-channel set |
| pair_diff | output | 4 | Active differential flag per pair |
| pair_swap | output | 4 | Per pair: 1 means the odd channel is positive |
| chan_bip | output | 8 | Active bipolar flag per channel |
| power_down | output | 1 | Power-down state |
| rd_load | output | 1 | One-cycle pulse when the read address is loaded |
| rd_addr | output | 3 | Read-port address |

## Verification
The assertions assume `wr_strobe`, `cs_n`, `wr_bus` and the strap inputs are synchronous to `clk`. They assume the bus is steady in the cycle where the strobe edge is seen, and that `hw_en` does not change in the cycle of a write. The stimulus changes every input only on the falling clock edge. It holds the bus and `hw_en` constant from one cycle before each strobe edge until one cycle after it, and it drops the strobe for at least one cycle between writes.

// File: rtl/chmux_cfg_pkg.sv
package chmux_cfg_pkg;

    localparam int NUM_CH   = 8;
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam int ADDR_W   = $clog2(NUM_CH);
    localparam int PAIR_W   = $clog2(NUM_PAIR);
    localparam int BUS_W    = 8;

    // bus field positions (decoded by the host side as well)
    localparam int F_PD   = 3;
    localparam int F_INH  = 4;
    localparam int F_BIP  = 5;
    localparam int F_DIFF = 6;
    localparam int F_ONE  = 7;

    typedef enum logic [1:0] {
        HW_SE_UNI   = 2'b00,
        HW_DIFF_UNI = 2'b01,
        HW_SE_BIP   = 2'b10,
        HW_DIFF_BIP = 2'b11
    } hw_arr_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              pd;
        logic              inh;
        logic              bip;
        logic              diff;
        logic              one;
    } wr_evt_t;

    function automatic wr_evt_t decode_bus(input logic [BUS_W-1:0] bus);
        wr_evt_t e;
        e.valid = 1'b0;
        e.addr  = bus[ADDR_W-1:0];
        e.pd    = bus[F_PD];
        e.inh   = bus[F_INH];
        e.bip   = bus[F_BIP];
        e.diff  = bus[F_DIFF];
        e.one   = bus[F_ONE];
        return e;
    endfunction

    function automatic logic [NUM_CH-1:0] ch_onehot(input logic [ADDR_W-1:0] a);
        logic [NUM_CH-1:0] m;
        m = '0;
        m[a] = 1'b1;
        return m;
    endfunction

    function automatic logic hw_is_diff(input hw_arr_t s);
        return (s == HW_DIFF_UNI) || (s == HW_DIFF_BIP);
    endfunction

    function automatic logic hw_is_bip(input hw_arr_t s);
        return (s == HW_SE_BIP) || (s == HW_DIFF_BIP);
    endfunction

endpackage

// File: rtl/chmux_wr_capture.sv
module chmux_wr_capture
    import chmux_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_strobe,
    input  logic [BUS_W-1:0] wr_bus,
    output wr_evt_t          evt
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= wr_strobe;
    end

    always_comb begin
        evt       = decode_bus(wr_bus);
        evt.valid = wr_strobe & ~strobe_q & ~cs_n;
    end

    // an accepted write needs a low strobe in the previous cycle (R1)
    p_single_edge_r1: assert property (@(posedge clk) disable iff (rst)
        evt.valid |-> !$past(wr_strobe));

endmodule

// File: rtl/chmux_cfg_store.sv
module chmux_cfg_store
    import chmux_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_evt_t           evt,
    input  logic              hw_en,
    output logic              conv_start,
    output logic [NUM_CH-1:0] conv_mask,
    output logic [NUM_CH-1:0] sel,
    output logic [NUM_PAIR-1:0] act_diff,
    output logic [NUM_PAIR-1:0] swap,
    output logic [NUM_CH-1:0] act_bip,
    output logic              pd,
    output logic              rd_load,
    output logic [ADDR_W-1:0] rd_addr
);

    logic               io_wr;
    logic               go;
    logic               io_go;
    logic [PAIR_W-1:0]  pair_idx;
    logic [NUM_CH-1:0]  pend_bip;
    logic [NUM_PAIR-1:0] pend_diff;

    assign io_wr    = evt.valid & ~hw_en;
    assign go       = evt.valid & (hw_en | (~evt.inh & ~evt.pd));
    assign io_go    = go & ~hw_en;
    assign pair_idx = evt.addr[ADDR_W-1:1];

    // per-channel selection and staged coding
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                sel[c]      <= 1'b0;
                pend_bip[c] <= 1'b0;
                act_bip[c]  <= 1'b0;
            end else begin
                if (io_go)
                    act_bip[c] <= pend_bip[c];
                if (io_wr && evt.addr == ADDR_W'(c)) begin
                    sel[c]      <= 1'b1;
                    pend_bip[c] <= evt.bip;
                end
            end
        end
    end

    // per-pair staged pairing and immediate polarity
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_diff[p] <= 1'b0;
                act_diff[p]  <= 1'b0;
                swap[p]      <= 1'b0;
            end else begin
                if (io_go)
                    act_diff[p] <= pend_diff[p];
                if (io_wr && pair_idx == PAIR_W'(p)) begin
                    pend_diff[p] <= evt.diff;
                    if (evt.diff)
                        swap[p] <= evt.addr[0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd         <= 1'b0;
            conv_start <= 1'b0;
            conv_mask  <= '0;
            rd_load    <= 1'b0;
            rd_addr    <= '0;
        end else begin
            conv_start <= go;
            rd_load    <= io_wr & evt.inh;
            if (io_wr) begin
                pd <= evt.pd;
                if (evt.inh)
                    rd_addr <= evt.addr;
            end
            if (go) begin
                if (hw_en)
                    conv_mask <= '1;
                else if (evt.one)
                    conv_mask <= ch_onehot(evt.addr);
                else
                    conv_mask <= sel | ch_onehot(evt.addr);
            end
        end
    end

    p_start_has_write_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(evt.valid));

    p_start_not_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !$past(hw_en)) |-> (!$past(evt.pd) && !$past(evt.inh)));

    p_sel_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (sel & $past(sel)) == $past(sel));

    p_active_only_at_start_r6: assert property (@(posedge clk) disable iff (rst)
        !conv_start |-> ($stable(act_diff) && $stable(act_bip)));

    p_hw_leaves_store_r10: assert property (@(posedge clk) disable iff (rst)
        $past(hw_en) |-> ($stable(sel) && $stable(pd) && $stable(swap)));

endmodule

// File: rtl/chmux_hw_override.sv
module chmux_hw_override
    import chmux_cfg_pkg::*;
(
    input  logic                hw_en,
    input  hw_arr_t             hw_arr,
    input  logic [NUM_PAIR-1:0] reg_diff,
    input  logic [NUM_PAIR-1:0] reg_swap,
    input  logic [NUM_CH-1:0]   reg_bip,
    input  logic                reg_pd,
    output logic [NUM_PAIR-1:0] eff_diff,
    output logic [NUM_PAIR-1:0] eff_swap,
    output logic [NUM_CH-1:0]   eff_bip,
    output logic                eff_pd
);

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign eff_diff[p] = hw_en ? hw_is_diff(hw_arr) : reg_diff[p];
        assign eff_swap[p] = hw_en ? 1'b0 : reg_swap[p];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign eff_bip[c] = hw_en ? hw_is_bip(hw_arr) : reg_bip[c];
    end

    assign eff_pd = reg_pd & ~hw_en;

endmodule

// File: rtl/chmux_cfg_reg.sv
module chmux_cfg_reg
    import chmux_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                wr_strobe,
    input  logic [BUS_W-1:0]    wr_bus,
    input  logic                hw_en,
    input  logic [1:0]          hw_sel,
    output logic                conv_start,
    output logic [NUM_CH-1:0]   conv_mask,
    output logic [NUM_CH-1:0]   chan_sel,
    output logic [NUM_PAIR-1:0] pair_diff,
    output logic [NUM_PAIR-1:0] pair_swap,
    output logic [NUM_CH-1:0]   chan_bip,
    output logic                power_down,
    output logic                rd_load,
    output logic [ADDR_W-1:0]   rd_addr
);

    wr_evt_t             evt;
    logic [NUM_PAIR-1:0] reg_diff;
    logic [NUM_PAIR-1:0] reg_swap;
    logic [NUM_CH-1:0]   reg_bip;
    logic                reg_pd;
    hw_arr_t             hw_arr;

    assign hw_arr = hw_arr_t'(hw_sel);

    chmux_wr_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wr_strobe (wr_strobe),
        .wr_bus    (wr_bus),
        .evt       (evt)
    );

    chmux_cfg_store u_store (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .hw_en      (hw_en),
        .conv_start (conv_start),
        .conv_mask  (conv_mask),
        .sel        (chan_sel),
        .act_diff   (reg_diff),
        .swap       (reg_swap),
        .act_bip    (reg_bip),
        .pd         (reg_pd),
        .rd_load    (rd_load),
        .rd_addr    (rd_addr)
    );

    chmux_hw_override u_hw (
        .hw_en    (hw_en),
        .hw_arr   (hw_arr),
        .reg_diff (reg_diff),
        .reg_swap (reg_swap),
        .reg_bip  (reg_bip),
        .reg_pd   (reg_pd),
        .eff_diff (pair_diff),
        .eff_swap (pair_swap),
        .eff_bip  (chan_bip),
        .eff_pd   (power_down)
    );

    p_single_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !$past(hw_en) && $past(wr_bus[F_ONE]))
            |-> (conv_mask == ch_onehot($past(wr_bus[ADDR_W-1:0]))));

    p_hw_full_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (conv_start && $past(hw_en)) |-> (conv_mask == '1));

    p_load_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> !rd_load);

endmodule

// File: tb/chmux_cfg_reg_test.sv
module chmux_cfg_reg_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_bus = '0;
    logic       hw_en = 1'b0;
    logic [1:0] hw_sel = '0;
    logic       conv_start;
    logic [7:0] conv_mask;
    logic [7:0] chan_sel;
    logic [3:0] pair_diff;
    logic [3:0] pair_swap;
    logic [7:0] chan_bip;
    logic       power_down;
    logic       rd_load;
    logic [2:0] rd_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [7:0] m_sel, m_pbip, m_abip;
    logic [3:0] m_pdiff, m_adiff, m_swap;
    logic       m_pd;
    logic [2:0] m_rd;
    logic       e_start, e_load;
    logic [7:0] e_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    chmux_cfg_reg uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_strobe(wr_strobe), .wr_bus(wr_bus),
        .hw_en(hw_en), .hw_sel(hw_sel), .conv_start(conv_start), .conv_mask(conv_mask),
        .chan_sel(chan_sel), .pair_diff(pair_diff), .pair_swap(pair_swap),
        .chan_bip(chan_bip), .power_down(power_down), .rd_load(rd_load), .rd_addr(rd_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = '0; m_pbip = '0; m_abip = '0;
        m_pdiff = '0; m_adiff = '0; m_swap = '0;
        m_pd = 1'b0; m_rd = '0;
        e_start = 1'b0; e_load = 1'b0; e_mask = '0;
    endtask

    task automatic model_write(input logic [7:0] d);
        logic [2:0] a;
        a = d[2:0];
        e_load = 1'b0;
        if (hw_en) begin
            e_start = 1'b1;
            e_mask  = 8'hFF;
        end else begin
            e_start = !d[4] && !d[3];
            if (e_start) begin
                m_adiff = m_pdiff;
                m_abip  = m_pbip;
            end
            m_sel[a]       = 1'b1;
            m_pbip[a]      = d[5];
            m_pdiff[a[2:1]] = d[6];
            if (d[6]) m_swap[a[2:1]] = a[0];
            m_pd = d[3];
            if (d[4]) begin
                m_rd   = a;
                e_load = 1'b1;
            end
            if (e_start) e_mask = d[7] ? (8'h01 << a) : m_sel;
        end
    endtask

    task automatic check_state(input string tag);
        if (hw_en) begin
            check({tag, " R10 diff"}, pair_diff, {4{hw_sel[0]}});
            check({tag, " R10 swap"}, pair_swap, 4'h0);
            check({tag, " R10 bip"},  chan_bip,  {8{hw_sel[1]}});
            check({tag, " R10 pd"},   power_down, 1'b0);
        end else begin
            check({tag, " R6 diff"}, pair_diff, m_adiff);
            check({tag, " R7 swap"}, pair_swap, m_swap);
            check({tag, " R6 bip"},  chan_bip,  m_abip);
            check({tag, " R8 pd"},   power_down, m_pd);
        end
        check({tag, " R4 sel"},  chan_sel, m_sel);
        check({tag, " R9 addr"}, rd_addr,  m_rd);
    endtask

    // one bus write, outputs sampled in the cycle after the strobe edge
    task automatic do_write(input logic [7:0] d, input logic cs_high, input string tag);
        @(negedge clk);
        cs_n = cs_high; wr_strobe = 1'b1; wr_bus = d;
        if (!cs_high) model_write(d);
        else begin e_start = 1'b0; e_load = 1'b0; end
        @(negedge clk);
        check({tag, " R3 start"}, conv_start, e_start);
        if (e_start) check({tag, " R5 mask"}, conv_mask, e_mask);
        check({tag, " R9 load"}, rd_load, e_load);
        check_state(tag);
        wr_strobe = 1'b0; cs_n = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R2 start", conv_start, 1'b0);
        check("R2 load",  rd_load, 1'b0);
        check_state("R2 reset");

        // exhaustive sweep of every bus value in register mode
        for (int d = 0; d < 256; d++)
            do_write(8'(d), 1'b0, "sweep");

        // pulses drop after one cycle
        @(negedge clk);
        check("R3 pulse ends", conv_start, 1'b0);
        check("R9 pulse ends", rd_load, 1'b0);

        // staged coding: pending values reach active only at next start
        do_reset();
        do_write(8'h75, 1'b0, "R6 stage");   // addr5 diff bip, inhibited
        check("R6 not yet bip", chan_bip, 8'h00);
        check("R7 swap now", pair_swap, 4'b0100);
        do_write(8'h05, 1'b0, "R6 go");      // start, own bits cleared
        check("R6 bip applied", chan_bip, 8'h20);
        check("R6 diff applied", pair_diff, 4'b0100);
        do_write(8'h44, 1'b0, "R7 last wins"); // addr4 diff: even positive
        check("R7 swap back", pair_swap, 4'b0000);
        do_write(8'h08, 1'b0, "R8 pd");
        do_write(8'h13, 1'b0, "R8 pd write kept");
        check("R4 kept in pd", chan_sel, 8'h39);

        // cs high and held strobe
        do_write(8'h07, 1'b1, "R1 cs high");
        check("R1 no select", chan_sel, 8'h39);
        @(negedge clk);
        cs_n = 1'b0; wr_strobe = 1'b1; wr_bus = 8'h02;
        model_write(8'h02);
        @(negedge clk);
        check("R1 first edge", conv_start, 1'b1);
        @(negedge clk);
        check("R1 held no repeat", conv_start, 1'b0);
        wr_strobe = 1'b0; cs_n = 1'b1;

        // strap arrangements
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            hw_en = 1'b1; hw_sel = 2'(s);
            do_write(8'h9F, 1'b0, "R10 hw");
            check("R10 sel untouched", chan_sel, m_sel);
        end
        @(negedge clk);
        hw_en = 1'b0;
        @(negedge clk);
        check_state("R10 restored");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule